// File: doc/BRIEF.md
# Twisted Pair Status Outputs

This block turns the internal state of an embedded 10BASE-T port into three status signals for the board: transmit-enable, receive-carrier and collision. The three signals share one output-enable that tells the pad ring when to drive them. The block also returns a collision indication to the MAC, and it raises a collision-error pulse when a transmission ends while the link is down. In that state the port sends no heartbeat, so a collision error is expected.

Its inputs are levels that other logic has already qualified: transmit activity, receive activity, link pass, jabber and sleep, plus a configuration bit that allows the pins to be driven. The port comes out of reset in link fail. Every output is registered, so it reflects the inputs sampled at the previous rising clock edge.

Top module: `tp_status_out`

## Requirements
- R1: While reset is asserted, every output is 0.
- R2: `pins_oe` is 1 only when `pins_en` is 1, `sleep` is 0, and `link_ok` has been 1 at least once since reset. After link pass has been seen, a later link fail does not clear `pins_oe`.
- R3: In link pass, with no jabber, `tx_en_o` follows `tx_act` and `rx_crs_o` follows `rx_act`, one clock after the inputs.
- R4: In link pass, when `tx_act` and `rx_act` are both 1, `tx_en_o`, `rx_crs_o`, `coll_o` and `mac_coll` are all 1 on the next clock.
- R5: When `link_ok` is 0, `tx_en_o`, `rx_crs_o`, `coll_o` and `mac_coll` are all 0 on the next clock.
- R6: In link pass with `jabber` at 1, `coll_o` and `mac_coll` are 1 and `tx_en_o` is 0 whatever `tx_act` is, and `rx_crs_o` follows `rx_act`.
- R7: When `sleep` is 1, `pins_oe` and all three pin values are 0, and so is `mac_coll`.
- R8: When `pins_en` is 0, `pins_oe` and all three pin values are 0, but `mac_coll` still reports collisions.
- R9: `coll_err` is a one-cycle pulse on the clock after `tx_act` falls while `link_ok` is 0 and `sleep` is 0. It never pulses when the fall happens in link pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_act | input | 1 | Qualified transmit activity |
| rx_act | input | 1 | Qualified receive activity |
| link_ok | input | 1 | Link pass state (0 = link fail) |
| jabber | input | 1 | Jabber mode active |
| sleep | input | 1 | Sleep request |
| pins_en | input | 1 | Configuration: allow status pins to be driven |
| tx_en_o | output | 1 | Transmit-enable pin value |
| rx_crs_o | output | 1 | Receive-carrier pin value |
| coll_o | output | 1 | Collision pin value |
| pins_oe | output | 1 | Shared output-enable for the three pins |
| mac_coll | output | 1 | Collision indication to the MAC |
| coll_err | output | 1 | Collision-error pulse (transmission ended during link fail) |

## Verification
Jabber and a plain collision can occur in the same cycle. Both raise `coll_o`, but jabber must also pull `tx_en_o` low while transmit and receive activity are both present. The bench drives jabber together with transmit and receive activity and expects collision and carrier high with transmit-enable low. Sleep and an active collision also meet in one vector, and there the bench expects every output to be quiet.

// File: rtl/tp_status_out.sv
module tp_status_out (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_act,
  input  logic rx_act,
  input  logic link_ok,
  input  logic jabber,
  input  logic sleep,
  input  logic pins_en,
  output logic tx_en_o,
  output logic rx_crs_o,
  output logic coll_o,
  output logic pins_oe,
  output logic mac_coll,
  output logic coll_err
);

  logic seen_q, tx_d;
  logic run, oe_n, txe_n, crs_n, col_n, err_n;

  assign run   = ~sleep & link_ok;
  assign oe_n  = ~sleep & pins_en & (seen_q | link_ok);
  assign txe_n = run & ~jabber & tx_act;
  assign crs_n = run & rx_act;
  assign col_n = run & (jabber | (tx_act & rx_act));
  assign err_n = ~sleep & ~link_ok & tx_d & ~tx_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q   <= 1'b0;
      tx_d     <= 1'b0;
      pins_oe  <= 1'b0;
      tx_en_o  <= 1'b0;
      rx_crs_o <= 1'b0;
      coll_o   <= 1'b0;
      mac_coll <= 1'b0;
      coll_err <= 1'b0;
    end else begin
      seen_q   <= seen_q | link_ok;
      tx_d     <= tx_act;
      pins_oe  <= oe_n;
      tx_en_o  <= oe_n & txe_n;
      rx_crs_o <= oe_n & crs_n;
      coll_o   <= oe_n & col_n;
      mac_coll <= col_n;
      coll_err <= err_n;
    end
  end

endmodule

// File: rtl/tp_status_out_chk.sv
module tp_status_out_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_act,
  input logic rx_act,
  input logic link_ok,
  input logic jabber,
  input logic sleep,
  input logic tx_en_o,
  input logic pins_oe,
  input logic mac_coll,
  input logic coll_err
);

  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (!pins_oe && !mac_coll)); // R7

  AST_JABBER_NO_TXEN: assert property (@(posedge clk) disable iff (!rst_n)
    jabber |=> !tx_en_o); // R6

  AST_LINK_FAIL_NO_COLL: assert property (@(posedge clk) disable iff (!rst_n)
    !link_ok |=> !mac_coll); // R5

  AST_COLL_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (link_ok && !sleep && tx_act && rx_act) |=> mac_coll); // R4

  AST_CERR_LINK_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    link_ok |=> !coll_err); // R9

endmodule

bind tp_status_out tp_status_out_chk i_chk (
  .clk(clk), .rst_n(rst_n), .tx_act(tx_act), .rx_act(rx_act),
  .link_ok(link_ok), .jabber(jabber), .sleep(sleep),
  .tx_en_o(tx_en_o), .pins_oe(pins_oe), .mac_coll(mac_coll), .coll_err(coll_err)
);

// File: tb/test_tp_status_out.sv
module test_tp_status_out;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_act = 0, rx_act = 0, link_ok = 0, jabber = 0, sleep = 0, pins_en = 0;
  logic tx_en_o, rx_crs_o, coll_o, pins_oe, mac_coll, coll_err;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  tp_status_out i_tp_status_out (
    .clk(clk), .rst_n(rst_n), .tx_act(tx_act), .rx_act(rx_act),
    .link_ok(link_ok), .jabber(jabber), .sleep(sleep), .pins_en(pins_en),
    .tx_en_o(tx_en_o), .rx_crs_o(rx_crs_o), .coll_o(coll_o),
    .pins_oe(pins_oe), .mac_coll(mac_coll), .coll_err(coll_err)
  );

  // in: {pins_en, sleep, jabber, link_ok, rx_act, tx_act}
  // out: {pins_oe, tx_en_o, rx_crs_o, coll_o, mac_coll}
  localparam int NV = 12;
  localparam logic [5:0] VIN [NV] = '{
    6'b100100, 6'b100101, 6'b100110, 6'b100111,
    6'b101100, 6'b101101, 6'b101111, 6'b100011,
    6'b110111, 6'b111111, 6'b000111, 6'b100111};
  localparam logic [4:0] VEXP [NV] = '{
    5'b10000, 5'b11000, 5'b10100, 5'b11111,
    5'b10011, 5'b10011, 5'b10111, 5'b10000,
    5'b00000, 5'b00000, 5'b00001, 5'b11111};
  localparam string VREQ [NV] = '{
    "R3", "R3", "R3", "R4", "R6", "R6", "R6", "R5 R2", "R7", "R7", "R8", "R4 R2"};

  function automatic logic [4:0] outs();
    return {pins_oe, tx_en_o, rx_crs_o, coll_o, mac_coll};
  endfunction

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(input logic [5:0] v);
    @(negedge clk);
    {pins_en, sleep, jabber, link_ok, rx_act, tx_act} = v;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog: got hang expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset with active inputs
    {pins_en, link_ok, tx_act, rx_act} = 4'b1111;
    repeat (3) @(posedge clk);
    #1;
    check("R1", {outs(), coll_err}, 6'b0);
    @(negedge clk);
    {pins_en, link_ok, tx_act, rx_act} = 4'b0;
    rst_n = 1'b1;
    // R2: enabled but never in link pass
    drive(6'b100011);
    check("R2", {outs(), coll_err}, 6'b0);
    drive(6'b100000);
    // R9: transmit ends in link fail -> pulse
    drive(6'b100001);
    drive(6'b100000);
    check("R9", {5'b0, coll_err}, 6'b000001);
    drive(6'b100000);
    check("R9", {5'b0, coll_err}, 6'b0);
    // R2: link pass opens the pins
    drive(6'b100100);
    check("R2", {outs(), coll_err}, 6'b100000);
    // R9: transmit ends in link pass -> no pulse
    drive(6'b100101);
    drive(6'b100100);
    check("R9", {5'b0, coll_err}, 6'b0);
    for (int i = 0; i < NV; i++) begin
      drive(VIN[i]);
      check(VREQ[i], {outs(), 1'b0}, {VEXP[i], 1'b0});
    end
    // R7: sleep in link fail suppresses the error pulse
    drive(6'b100001);
    drive(6'b110000);
    check("R7 R9", {outs(), coll_err}, 6'b0);
    // R2: after sleep clears, link fail keeps oe because link was seen
    drive(6'b100000);
    check("R2", {outs(), coll_err}, 6'b100000);
    // R1: reset again, then link fail keeps pins undriven
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", {outs(), coll_err}, 6'b0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(6'b100011);
    check("R2", {outs(), coll_err}, 6'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule